// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a logical address, made of a segment-register number and an offset, to a physical address. Each segment register has a hidden cache entry that holds a base, an effective limit and two access permissions. Every translation reads only that cache entry, so the result does not depend on the current mode. Only the way a load fills the entry depends on the mode.

In real mode a load finishes in one cycle. The cache entry gets a base equal to the selector times sixteen, a 64 KiB limit, and both read and write permission. In protected mode a load first reads a 64-bit descriptor through a request/valid read port. The address is a table base plus eight times the selector index. The block checks the descriptor against the rules for the target register. If it passes, the descriptor's base, limit and rights go into the cache. If it fails, the cache entry stays unchanged and the load reports a fault. Changing the mode input never touches the caches. Values loaded in real mode therefore stay usable in protected mode until that register is reloaded.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset, every cache entry has base 0, limit 0x0000FFFF, and read and write permission. During reset `tr_valid`, `tr_fault`, `ld_done`, `ld_fault` and `desc_rd_req` are low.
- R2: A load accepted while `prot_mode`=0 writes base = selector×16, limit 0xFFFF and read+write permission. `ld_done` is high in the next cycle with `ld_fault` low, and no descriptor read is issued.
- R3: A translate request sampled at a clock edge gives `tr_valid` in the next cycle. When there is no fault, `tr_addr` = cached base + offset, modulo 2^32. The translation uses the cache contents from before any load that completes at the same edge.
- R4: When the offset is greater than the effective limit, `tr_fault` goes high and `tr_addr` reads 0.
- R5: A load accepted while `prot_mode`=1 raises `desc_rd_req` with `desc_rd_addr` = `tbl_base` + selector[15:3]×8. Both stay unchanged until `desc_rd_valid` is sampled high. `ld_done` is high in the cycle after that.
- R6: Descriptor fields are assembled as follows. Base = {d[63:56], d[39:32], d[31:16]}. Raw limit = {d[51:48], d[15:0]}. When G (d[55]) is 1, the effective limit is raw limit shifted left by 12 with 0xFFF in the low bits; otherwise it is the raw limit.
- R7: A descriptor with the present bit (d[47]) equal to 0 is rejected. `ld_fault` is high together with `ld_done`, and the target cache entry stays unchanged.
- R8: For target register 0 (code), the descriptor needs S (d[44])=1 and executable (d[43])=1. Otherwise it is rejected.
- R9: For target register 1 (stack), the descriptor needs S=1, executable=0 and R/W (d[41])=1. Any descriptor acceptable for register 0 is therefore rejected.
- R10: For target registers 2 and 3 (data), the descriptor needs S=1. If it is executable, it also needs R/W=1 (readable code).
- R11: Write permission is (executable=0 and R/W=1). Read permission is (executable=0 or R/W=1). A write translation without write permission, or a read translation without read permission, faults.
- R12: Changing `prot_mode` leaves all cache entries unchanged.
- R13: A load request that arrives while a descriptor fetch is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_mode | input | 1 | 1 selects protected-mode loads |
| tbl_base | input | 32 | Descriptor table base address |
| ld_req | input | 1 | Segment load request |
| ld_seg | input | 2 | Target segment register (0 code, 1 stack, 2/3 data) |
| ld_sel | input | 16 | Selector value to load |
| ld_done | output | 1 | Load finished (one-cycle pulse) |
| ld_fault | output | 1 | Load rejected; valid with ld_done |
| desc_rd_req | output | 1 | Descriptor read request |
| desc_rd_addr | output | 32 | Descriptor read address |
| desc_rd_valid | input | 1 | Descriptor data valid |
| desc_rd_data | input | 64 | Descriptor returned |
| tr_req | input | 1 | Translate request |
| tr_seg | input | 2 | Segment register used for translation |
| tr_off | input | 32 | Effective offset |
| tr_wr | input | 1 | 1 for write access, 0 for read |
| tr_valid | output | 1 | Translation result valid |
| tr_addr | output | 32 | Physical address, 0 on fault |
| tr_fault | output | 1 | Limit or access-right violation |

## Verification
The assertions check the handshake properties on every cycle. The descriptor request stays high with a stable address until data arrives. A load completes one cycle after data arrives, and a real-mode load completes in one cycle with no read issued. Translation latency is one cycle, and a faulting translation returns a zero address. The rest can only be shown by the bench's scenarios: whether the right base and limit land in the right cache entry, and which descriptor kinds each target register accepts or rejects. Those scenarios also show that a rejected load or a mode change leaves the caches alone, and that a second request during a pending fetch is dropped.

// File: rtl/seg_xlat_pkg.sv
// Shared types for the segment translation unit.
// Assumes 32-bit linear addresses and 64-bit descriptors.
package seg_xlat_pkg;
    localparam int ADDR_W = 32;
    localparam int DESC_W = 64;
    localparam int SEL_W  = 16;

    // One hidden cache entry per segment register
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] lim;
        logic              wr_ok;
        logic              rd_ok;
    } seg_entry_t;

    typedef enum logic {LD_IDLE, LD_WAIT} ld_state_t;
endpackage

// File: rtl/seg_desc_check.sv
// Decodes a 64-bit descriptor into a cache entry and decides whether it
// may be loaded into the target register. Purely combinational.
// Assumes the caller flags the code and stack targets.
module seg_desc_check
    import seg_xlat_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic              is_code,
    input  logic              is_stack,
    output seg_entry_t        entry,
    output logic              ok
);
    logic [19:0] raw_lim;
    logic        gran, present, sflag, exec, rw;
    logic        unused_desc_bits;

    assign raw_lim = {desc[51:48], desc[15:0]};
    assign gran    = desc[55];
    assign present = desc[47];
    assign sflag   = desc[44];
    assign exec    = desc[43];
    assign rw      = desc[41];
    assign unused_desc_bits = ^{desc[54:52], desc[46:45], desc[42], desc[40]};

    // Assemble the entry fields from the split descriptor
    always_comb begin
        entry.base  = {desc[63:56], desc[39:32], desc[31:16]};
        entry.lim   = gran ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
        entry.wr_ok = !exec && rw;
        entry.rd_ok = !exec || rw;
    end

    // Target-specific acceptance rule
    always_comb begin
        if (is_code)       ok = present && sflag && exec;
        else if (is_stack) ok = present && sflag && !exec && rw;
        else               ok = present && sflag && (!exec || rw);
    end
endmodule

// File: rtl/seg_cache_file.sv
// Hidden descriptor cache: one entry per segment register, one write
// port and one combinational read port. Assumes a synchronous active-low reset.
module seg_cache_file
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEG = 4,
    localparam int IDX_W = $clog2(NUM_SEG)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  seg_entry_t       wdata,
    input  logic [IDX_W-1:0] ridx,
    output seg_entry_t       rdata
);
    seg_entry_t ent [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        // Hold or replace entry g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g].base  <= '0;
                ent[g].lim   <= 32'h0000_FFFF;
                ent[g].wr_ok <= 1'b1;
                ent[g].rd_ok <= 1'b1;
            end else if (we && widx == IDX_W'(g)) begin
                ent[g] <= wdata;
            end
        end
    end

    assign rdata = ent[ridx];
endmodule

// File: rtl/seg_xlate_stage.sv
// One-cycle translation stage: base plus offset, with limit and access
// checks. Assumes the cache entry for the request is presented combinationally.
module seg_xlate_stage
    import seg_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] off,
    input  logic              wr,
    input  seg_entry_t        ent,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic              fault
);
    logic bad;
    assign bad = (off > ent.lim) || (wr && !ent.wr_ok) || (!wr && !ent.rd_ok);

    // Register the translation result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            fault <= 1'b0;
            addr  <= '0;
        end else begin
            valid <= req;
            fault <= req && bad;
            addr  <= (req && !bad) ? ent.base + off : '0;
        end
    end
endmodule

// File: rtl/seg_xlat_unit.sv
// Segment translation unit top. It sequences segment loads (a one-cycle
// fill in real mode, a descriptor fetch and check in protected mode) and
// serves translations from the hidden caches. Assumes the descriptor
// source holds data until the request drops.
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int CS_IDX  = 0,
    parameter int SS_IDX  = 1,
    localparam int IDX_W  = $clog2(NUM_SEG)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode,
    input  logic [31:0]       tbl_base,
    input  logic              ld_req,
    input  logic [IDX_W-1:0]  ld_seg,
    input  logic [15:0]       ld_sel,
    output logic              ld_done,
    output logic              ld_fault,
    output logic              desc_rd_req,
    output logic [31:0]       desc_rd_addr,
    input  logic              desc_rd_valid,
    input  logic [63:0]       desc_rd_data,
    input  logic              tr_req,
    input  logic [IDX_W-1:0]  tr_seg,
    input  logic [31:0]       tr_off,
    input  logic              tr_wr,
    output logic              tr_valid,
    output logic [31:0]       tr_addr,
    output logic              tr_fault
);
    ld_state_t        state;
    logic [IDX_W-1:0] pend_seg;
    seg_entry_t       real_ent, chk_ent, wr_ent, rd_ent;
    logic             chk_ok, take_real, take_prot, fetch_end, we;
    logic [IDX_W-1:0] widx;

    assign take_real = (state == LD_IDLE) && ld_req && !prot_mode;
    assign take_prot = (state == LD_IDLE) && ld_req && prot_mode;
    assign fetch_end = (state == LD_WAIT) && desc_rd_valid;

    // Real-mode entry: paragraph base, 64 KiB limit, full access
    always_comb begin
        real_ent.base  = {12'h000, ld_sel, 4'h0};
        real_ent.lim   = 32'h0000_FFFF;
        real_ent.wr_ok = 1'b1;
        real_ent.rd_ok = 1'b1;
    end

    seg_desc_check u_chk_desc (
        .desc     (desc_rd_data),
        .is_code  (pend_seg == IDX_W'(CS_IDX)),
        .is_stack (pend_seg == IDX_W'(SS_IDX)),
        .entry    (chk_ent),
        .ok       (chk_ok)
    );

    assign we     = take_real || (fetch_end && chk_ok);
    assign widx   = take_real ? ld_seg : pend_seg;
    assign wr_ent = take_real ? real_ent : chk_ent;

    seg_cache_file #(.NUM_SEG(NUM_SEG)) u_cache (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .widx  (widx),
        .wdata (wr_ent),
        .ridx  (tr_seg),
        .rdata (rd_ent)
    );

    seg_xlate_stage u_xlate (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (tr_req),
        .off   (tr_off),
        .wr    (tr_wr),
        .ent   (rd_ent),
        .valid (tr_valid),
        .addr  (tr_addr),
        .fault (tr_fault)
    );

    // Load sequencer: accept, fetch, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= LD_IDLE;
            pend_seg     <= '0;
            desc_rd_addr <= '0;
            ld_done      <= 1'b0;
            ld_fault     <= 1'b0;
        end else begin
            ld_done  <= take_real || fetch_end;
            ld_fault <= fetch_end && !chk_ok;
            if (take_prot) begin
                state        <= LD_WAIT;
                pend_seg     <= ld_seg;
                desc_rd_addr <= tbl_base + {16'h0000, ld_sel[15:3], 3'b000};
            end else if (fetch_end) begin
                state <= LD_IDLE;
            end
        end
    end

    assign desc_rd_req = (state == LD_WAIT);
endmodule

// File: rtl/seg_xlat_chk.sv
// Protocol checker for seg_xlat_unit, attached by bind.
module seg_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        prot_mode,
    input logic        ld_req,
    input logic        ld_done,
    input logic        ld_fault,
    input logic        desc_rd_req,
    input logic [31:0] desc_rd_addr,
    input logic        desc_rd_valid,
    input logic        tr_req,
    input logic        tr_valid,
    input logic [31:0] tr_addr,
    input logic        tr_fault
);
    // R5
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_req && !desc_rd_valid |=> desc_rd_req && $stable(desc_rd_addr));
    // R5
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_req && desc_rd_valid |=> ld_done && !desc_rd_req);
    // R2
    real_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req && !prot_mode && !desc_rd_req |=> ld_done && !ld_fault && !desc_rd_req);
    // R3
    xlate_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_req |=> tr_valid);
    // R3
    xlate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tr_req |=> !tr_valid && !tr_fault);
    // R4
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_fault |-> tr_valid && tr_addr == 32'h0);
    // R7
    ld_fault_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault |-> ld_done);
endmodule

bind seg_xlat_unit seg_xlat_chk u_seg_xlat_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prot_mode     (prot_mode),
    .ld_req        (ld_req),
    .ld_done       (ld_done),
    .ld_fault      (ld_fault),
    .desc_rd_req   (desc_rd_req),
    .desc_rd_addr  (desc_rd_addr),
    .desc_rd_valid (desc_rd_valid),
    .tr_req        (tr_req),
    .tr_valid      (tr_valid),
    .tr_addr       (tr_addr),
    .tr_fault      (tr_fault)
);

// File: tb/seg_xlat_unit_tb.sv
// Bench: behavioural reference model compared with the design every cycle.
module seg_xlat_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TBASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode = 1'b0;
    logic [31:0] tbl_base = TBASE;
    logic        ld_req = 1'b0;
    logic [1:0]  ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic        ld_done, ld_fault, desc_rd_req;
    logic [31:0] desc_rd_addr;
    logic        desc_rd_valid = 1'b0;
    logic [63:0] desc_rd_data = '0;
    logic        tr_req = 1'b0;
    logic [1:0]  tr_seg = '0;
    logic [31:0] tr_off = '0;
    logic        tr_wr = 1'b0;
    logic        tr_valid, tr_fault;
    logic [31:0] tr_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .tbl_base(tbl_base),
        .ld_req(ld_req), .ld_seg(ld_seg), .ld_sel(ld_sel),
        .ld_done(ld_done), .ld_fault(ld_fault),
        .desc_rd_req(desc_rd_req), .desc_rd_addr(desc_rd_addr),
        .desc_rd_valid(desc_rd_valid), .desc_rd_data(desc_rd_data),
        .tr_req(tr_req), .tr_seg(tr_seg), .tr_off(tr_off), .tr_wr(tr_wr),
        .tr_valid(tr_valid), .tr_addr(tr_addr), .tr_fault(tr_fault)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    int    lat_cfg = 0;
    int    wait_cnt = 0;
    bit    started = 0;
    logic [63:0] dmem [8];

    // reference model state
    logic [31:0] mb [4];
    logic [31:0] ml [4];
    bit          mw [4];
    bit          mr [4];
    bit          m_busy = 0;
    int          m_seg = 0;
    bit          e_tv = 0, e_tf = 0, e_ld = 0, e_lf = 0;
    logic [31:0] e_ta = '0, e_ra = '0;

    function automatic logic [63:0] mkdesc(input logic [31:0] b, input logic [19:0] l,
                                           input logic [7:0] acc, input bit g);
        logic [63:0] d;
        d = '0;
        d[15:0]  = l[15:0];
        d[51:48] = l[19:16];
        d[31:16] = b[15:0];
        d[39:32] = b[23:16];
        d[63:56] = b[31:24];
        d[47:40] = acc;
        d[55]    = g;
        return d;
    endfunction

    // Model: advance one clock with the inputs present at this edge
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                mb[i] = 0; ml[i] = 32'hFFFF; mw[i] = 1; mr[i] = 1;
            end
            m_busy = 0; e_tv = 0; e_tf = 0; e_ta = 0; e_ld = 0; e_lf = 0; e_ra = 0;
        end else begin
            e_tv = tr_req; e_tf = 0; e_ta = 0;
            if (tr_req) begin
                if (tr_off > ml[tr_seg] || (tr_wr && !mw[tr_seg]) || (!tr_wr && !mr[tr_seg]))
                    e_tf = 1;
                else
                    e_ta = mb[tr_seg] + tr_off;
            end
            e_ld = 0; e_lf = 0;
            if (m_busy) begin
                if (desc_rd_valid) begin
                    logic [63:0] d;
                    bit okay, x, rw;
                    d = desc_rd_data;
                    x = d[43]; rw = d[41];
                    okay = d[47] && d[44];
                    if (m_seg == 0) okay = okay && x;
                    else if (m_seg == 1) okay = okay && !x && rw;
                    else okay = okay && (!x || rw);
                    if (okay) begin
                        mb[m_seg] = {d[63:56], d[39:32], d[31:16]};
                        ml[m_seg] = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'h0, d[51:48], d[15:0]};
                        mw[m_seg] = !x && rw;
                        mr[m_seg] = !x || rw;
                    end
                    e_ld = 1; e_lf = !okay; m_busy = 0;
                end
            end else if (ld_req) begin
                if (!prot_mode) begin
                    mb[ld_seg] = {12'h0, ld_sel, 4'h0};
                    ml[ld_seg] = 32'hFFFF; mw[ld_seg] = 1; mr[ld_seg] = 1;
                    e_ld = 1;
                end else begin
                    m_busy = 1; m_seg = ld_seg;
                    e_ra = TBASE + 32'(ld_sel[15:3]) * 8;
                end
            end
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare at the falling edge, then act as descriptor memory
    always @(negedge clk) begin
        if (started) begin
            cmp("tr_valid", 32'(tr_valid), 32'(e_tv));
            cmp("tr_fault", 32'(tr_fault), 32'(e_tf));
            cmp("tr_addr", tr_addr, e_ta);
            cmp("ld_done", 32'(ld_done), 32'(e_ld));
            cmp("ld_fault", 32'(ld_fault), 32'(e_lf));
            cmp("desc_rd_req", 32'(desc_rd_req), 32'(m_busy));
            if (m_busy) cmp("desc_rd_addr", desc_rd_addr, e_ra);
        end
        if (desc_rd_req === 1'b1 && !desc_rd_valid) begin
            if (wait_cnt >= lat_cfg) begin
                desc_rd_valid <= 1'b1;
                desc_rd_data  <= dmem[3'((desc_rd_addr - TBASE) >> 3)];
                wait_cnt = 0;
            end else wait_cnt++;
        end else begin
            desc_rd_valid <= 1'b0;
        end
    end

    task automatic xl(input int seg, input logic [31:0] off, input bit wr);
        @(posedge clk); #1;
        tr_req = 1; tr_seg = 2'(seg); tr_off = off; tr_wr = wr;
        @(posedge clk); #1;
        tr_req = 0;
    endtask

    task automatic ld(input int seg, input logic [15:0] sel, input bit extra);
        @(posedge clk); #1;
        ld_req = 1; ld_seg = 2'(seg); ld_sel = sel;
        @(posedge clk); #1;
        ld_req = extra; ld_seg = 2'(3 - seg); ld_sel = 16'h0038;
        while (m_busy) begin
            @(posedge clk); #1;
        end
        ld_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        dmem[0] = '0;
        dmem[1] = mkdesc(32'h1234_5678, 20'h00FFF, 8'h92, 0);
        dmem[2] = mkdesc(32'hAB00_0000, 20'h00002, 8'h90, 1);
        dmem[3] = mkdesc(32'h0040_0000, 20'h0FFFF, 8'h9A, 0);
        dmem[4] = mkdesc(32'h0900_0000, 20'hFFFFF, 8'h12, 0);
        dmem[5] = mkdesc(32'h0020_0000, 20'hFFFFF, 8'h92, 0);
        dmem[6] = mkdesc(32'h0060_0000, 20'h0FFFF, 8'h98, 0);
        dmem[7] = mkdesc(32'h0070_0000, 20'h0FFFF, 8'h82, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset cache contents
        cur_req = "R1";
        for (int s = 0; s < 4; s++) xl(s, 32'h1234, s[0]);
        cur_req = "R4"; xl(2, 32'h0001_0000, 0);
        // R2 / R3 real-mode loads and translation
        cur_req = "R2"; ld(2, 16'h1234, 0);
        cur_req = "R3"; xl(2, 32'h10, 0); xl(2, 32'h10, 1);
        cur_req = "R2"; ld(0, 16'hFFFF, 0); xl(0, 32'hFFFF, 0);
        cur_req = "R4"; xl(0, 32'h1_0000, 0);
        // R12 entering protected mode keeps caches
        @(posedge clk); #1 prot_mode = 1;
        cur_req = "R12"; xl(2, 32'h10, 1); xl(0, 32'hFFFF, 0);
        // R5 / R13 / R6 fetch with latency and a dropped second request
        lat_cfg = 3;
        cur_req = "R13"; ld(2, 16'h0008, 1);
        cur_req = "R6"; xl(2, 32'hFFF, 1); xl(2, 32'h1000, 0);
        lat_cfg = 0;
        cur_req = "R5"; ld(3, 16'h0013, 0);
        cur_req = "R11"; xl(3, 32'h2FFF, 0); xl(3, 32'h10, 1);
        cur_req = "R6"; xl(3, 32'h3000, 0);
        cur_req = "R8"; ld(0, 16'h0018, 0); xl(0, 32'h20, 0);
        cur_req = "R11"; xl(0, 32'h20, 1);
        cur_req = "R9"; ld(1, 16'h0018, 0); xl(1, 32'h40, 1);
        cur_req = "R7"; ld(2, 16'h0020, 0); xl(2, 32'hFFF, 1);
        cur_req = "R8"; ld(0, 16'h0028, 0); xl(0, 32'h20, 0);
        cur_req = "R9"; ld(1, 16'h0028, 0); xl(1, 32'h40, 1);
        cur_req = "R10"; ld(3, 16'h0030, 0); xl(3, 32'h20, 0);
        cur_req = "R11"; ld(0, 16'h0030, 0); xl(0, 32'h20, 0); xl(0, 32'h20, 1);
        cur_req = "R10"; ld(2, 16'h0038, 0); xl(2, 32'h20, 0);
        // R12 leaving protected mode keeps caches, then a real load
        @(posedge clk); #1 prot_mode = 0;
        cur_req = "R12"; xl(1, 32'h40, 1); xl(2, 32'hFFF, 1);
        cur_req = "R2"; ld(1, 16'h0000, 0); xl(1, 32'hFFFF, 1);
        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule